// File: doc/BRIEF.md
# Prioritised Trigger Channel Combiner

This block merges sixteen internal trigger channels into one trigger request and a 4-bit trigger type. Each channel has its own enable and can be set to react either to a high level or to a rising edge. On any cycle where at least one enabled channel is active and the downstream logic is not busy, the block raises its trigger output. The type that goes with the trigger is looked up from a per-channel table, using the lowest-numbered active channel.

Software sets up the block through a simple strobe-based register port. One control word holds the enables and the sensitivity selects. Two words hold the type table. Each channel also has two statistics counters: one counts the cycles in which the channel is high, the other counts its rising edges. The counters can be read through the same port. The counters watch the raw channel inputs and do not depend on the enables, so the activity of a channel can be measured before that channel is allowed to trigger.

Top module: `trig_combiner`

## Requirements
- R1: After reset the trigger output is low, the type output is 0, all channels are disabled and the control word and both type words read back as 0.
- R2: The control word sits at address 0x00. Bit c (c = 0..15) enables channel c when 1. Bit 16+c selects level sensitivity for channel c when 1 and edge sensitivity when 0. The word reads back as written.
- R3: A channel whose enable bit is 0 never causes a trigger, however its input behaves.
- R4: A level-sensitive enabled channel keeps the trigger output high for every cycle the channel is high. A channel change applied before clock edge k shows at the trigger output after edge k+1 (two cycles of latency).
- R5: An edge-sensitive enabled channel produces a trigger lasting exactly one cycle for each rising edge. A rising edge is a high sample whose sample one cycle earlier was low. Holding the channel high gives no further triggers.
- R6: The type table is held in two words: address 0x01 for channels 0..7 and address 0x02 for channels 8..15. Channel c uses bits 4*(c mod 8)+3 : 4*(c mod 8) of its word. Both words read back as written.
- R7: When several enabled channels are active in the same cycle, the type output takes the type of the lowest-numbered one.
- R8: While the busy input is high, no trigger is produced in the following cycle. Edge events that fall in that time are dropped and are not replayed later.
- R9: The type output is loaded only when a trigger starts (trigger output going from low to high). It stays stable while the trigger output stays high, even if a lower-numbered channel becomes active.
- R10: For channel c, the level counter at address 0x10+2c counts the clock cycles in which the channel input is high, whether or not the channel is enabled.
- R11: For channel c, the edge counter at address 0x11+2c counts the rising edges of the channel input, whether or not the channel is enabled.
- R12: The counters are CNT_W bits wide (32 by default). They wrap to zero with no indication, and read back zero-extended to the data width.
- R13: A read strobe gives a read-valid pulse and the read data exactly one cycle later. The read-valid pulse appears only after a read strobe. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | NUM_CH | Internal trigger channel inputs |
| busy_i | input | 1 | Blocks new triggers while high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| trig_o | output | 1 | Combined trigger request |
| trig_type_o | output | TYPE_W | Type of the current trigger |

## Verification
The combiner is driven with these patterns:
- one level-sensitive channel held high over several cycles, which separates level behaviour from edge behaviour and pins down the two-cycle latency;
- one edge-sensitive channel held high, which must give a single pulse;
- two channels rising together, which shows whether the lowest index wins the type lookup;
- an edge that arrives while busy is high, which shows whether the event is dropped or only delayed;
- a lower channel joining during a continuous level trigger, which shows whether the type is held or rewritten in the middle of a trigger.

A reference model in the bench tracks every cycle, including the counters of channels that are disabled. A reduced counter width makes wrap-around reachable within a few hundred cycles.

// File: rtl/trgc_pkg.sv
package trgc_pkg;

    // Register word addresses of the configuration block
    localparam int unsigned CTRL_ADDR        = 0;
    localparam int unsigned TYPE_ADDR        = 1;
    localparam int unsigned DEFAULT_CNT_BASE = 16;

    // Address of one statistics counter: two words per channel, level count first
    function automatic int unsigned cnt_addr(input int unsigned base,
                                             input int unsigned ch,
                                             input bit          is_edge);
        return base + 2 * ch + (is_edge ? 1 : 0);
    endfunction

endpackage

// File: rtl/trgc_cfg_regs.sv
module trgc_cfg_regs #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned TYPE_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [NUM_CH-1:0]        en_o,
    output logic [NUM_CH-1:0]        lvl_o,
    output logic [NUM_CH*TYPE_W-1:0] type_tab_o,
    output logic [DATA_W-1:0]        rd_val_o
);
    import trgc_pkg::*;

    localparam int unsigned TAB_W   = NUM_CH * TYPE_W;
    localparam int unsigned NTREG   = (TAB_W + DATA_W - 1) / DATA_W;
    localparam int unsigned STORE_W = NTREG * DATA_W;

    typedef struct packed {
        logic [NUM_CH-1:0]             en;
        logic [NUM_CH-1:0]             lvl;
        logic [NTREG-1:0][DATA_W-1:0]  types;
    } cfg_t;

    cfg_t s_d, s_q;
    logic [STORE_W-1:0] tab_flat;

    always_comb begin
        s_d      = s_q;
        rd_val_o = '0;
        if (wr_i) begin
            if (addr_i == ADDR_W'(CTRL_ADDR)) begin
                s_d.en  = wdata_i[NUM_CH-1:0];
                s_d.lvl = wdata_i[2*NUM_CH-1:NUM_CH];
            end
            for (int r = 0; r < NTREG; r++) begin
                if (addr_i == ADDR_W'(TYPE_ADDR + r)) begin
                    s_d.types[r] = wdata_i;
                end
            end
        end
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            rd_val_o[2*NUM_CH-1:0] = {s_q.lvl, s_q.en};
        end
        for (int r = 0; r < NTREG; r++) begin
            if (addr_i == ADDR_W'(TYPE_ADDR + r)) begin
                rd_val_o = s_q.types[r];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o       = s_q.en;
    assign lvl_o      = s_q.lvl;
    assign tab_flat   = s_q.types;
    assign type_tab_o = tab_flat[TAB_W-1:0];

endmodule

// File: rtl/trgc_detect.sv
module trgc_detect #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] chan_i,
    input  logic [NUM_CH-1:0] en_i,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] active_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] prev;
        logic [NUM_CH-1:0] active;
    } det_t;

    det_t s_d, s_q;

    assign rise_o = chan_i & ~s_q.prev;

    always_comb begin
        s_d      = s_q;
        s_d.prev = chan_i;
        for (int c = 0; c < NUM_CH; c++) begin
            s_d.active[c] = en_i[c] & (lvl_i[c] ? chan_i[c] : rise_o[c]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;

endmodule

// File: rtl/trgc_arbiter.sv
module trgc_arbiter #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned TYPE_W = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH-1:0]        active_i,
    input  logic                     busy_i,
    input  logic [NUM_CH*TYPE_W-1:0] type_tab_i,
    output logic                     trig_o,
    output logic [TYPE_W-1:0]        type_o
);
    typedef struct packed {
        logic              trig;
        logic [TYPE_W-1:0] typ;
    } arb_t;

    arb_t              s_d, s_q;
    logic [TYPE_W-1:0] win_type;

    always_comb begin
        // downward scan: the last hit is the lowest index
        win_type = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (active_i[c]) begin
                win_type = type_tab_i[c*TYPE_W +: TYPE_W];
            end
        end
        s_d      = s_q;
        s_d.trig = (|active_i) & ~busy_i;
        if (s_d.trig && !s_q.trig) begin
            s_d.typ = win_type;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign trig_o = s_q.trig;
    assign type_o = s_q.typ;

endmodule

// File: rtl/trgc_stats.sv
module trgc_stats #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_CH-1:0]            chan_i,
    input  logic [NUM_CH-1:0]            rise_i,
    output logic [NUM_CH-1:0][CNT_W-1:0] lvl_cnt_o,
    output logic [NUM_CH-1:0][CNT_W-1:0] edge_cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] lvl;
        logic [CNT_W-1:0] edg;
    } cnt_t;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cnt_t s_d, s_q;

        always_comb begin
            s_d = s_q;
            if (chan_i[c]) begin
                s_d.lvl = s_q.lvl + CNT_W'(1);
            end
            if (rise_i[c]) begin
                s_d.edg = s_q.edg + CNT_W'(1);
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                s_q <= '0;
            end else begin
                s_q <= s_d;
            end
        end

        assign lvl_cnt_o[c]  = s_q.lvl;
        assign edge_cnt_o[c] = s_q.edg;
    end

endmodule

// File: rtl/trig_combiner.sv
module trig_combiner #(
    parameter int unsigned NUM_CH   = 16,
    parameter int unsigned TYPE_W   = 4,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned CNT_BASE = trgc_pkg::DEFAULT_CNT_BASE
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] chan_i,
    input  logic              busy_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              reg_rvalid_o,
    output logic              trig_o,
    output logic [TYPE_W-1:0] trig_type_o
);
    import trgc_pkg::*;

    typedef struct packed {
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } rd_t;

    logic [NUM_CH-1:0]             cfg_en;
    logic [NUM_CH-1:0]             cfg_lvl;
    logic [NUM_CH*TYPE_W-1:0]      type_tab;
    logic [DATA_W-1:0]             cfg_val;
    logic [NUM_CH-1:0]             rise;
    logic [NUM_CH-1:0]             active;
    logic [NUM_CH-1:0][CNT_W-1:0]  lvl_cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]  edge_cnt;
    logic [DATA_W-1:0]             rd_val;
    rd_t                           r_d, r_q;

    trgc_cfg_regs #(
        .NUM_CH(NUM_CH), .TYPE_W(TYPE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .en_o       (cfg_en),
        .lvl_o      (cfg_lvl),
        .type_tab_o (type_tab),
        .rd_val_o   (cfg_val)
    );

    trgc_detect #(.NUM_CH(NUM_CH)) u_detect (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .chan_i   (chan_i),
        .en_i     (cfg_en),
        .lvl_i    (cfg_lvl),
        .rise_o   (rise),
        .active_o (active)
    );

    trgc_arbiter #(.NUM_CH(NUM_CH), .TYPE_W(TYPE_W)) u_arb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .active_i   (active),
        .busy_i     (busy_i),
        .type_tab_i (type_tab),
        .trig_o     (trig_o),
        .type_o     (trig_type_o)
    );

    trgc_stats #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_stats (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .chan_i     (chan_i),
        .rise_i     (rise),
        .lvl_cnt_o  (lvl_cnt),
        .edge_cnt_o (edge_cnt)
    );

    always_comb begin
        rd_val = cfg_val;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr_i == ADDR_W'(cnt_addr(CNT_BASE, c, 1'b0))) begin
                rd_val = DATA_W'(lvl_cnt[c]);
            end
            if (reg_addr_i == ADDR_W'(cnt_addr(CNT_BASE, c, 1'b1))) begin
                rd_val = DATA_W'(edge_cnt[c]);
            end
        end
        r_d        = r_q;
        r_d.rvalid = reg_rd_i;
        r_d.rdata  = reg_rd_i ? rd_val : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reg_rdata_o  = r_q.rdata;
    assign reg_rvalid_o = r_q.rvalid;

endmodule

// File: rtl/trig_combiner_chk.sv
module trig_combiner_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned TYPE_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              busy_i,
    input logic              reg_rd_i,
    input logic              reg_rvalid_o,
    input logic              trig_o,
    input logic [TYPE_W-1:0] trig_type_o,
    input logic [NUM_CH-1:0] cfg_en
);
    AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_en) == '0) |=> !trig_o); // R3

    AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> !trig_o); // R8

    AST_TYPE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> (!trig_o || $stable(trig_type_o))); // R9

    AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rd_i |=> reg_rvalid_o); // R13

    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !reg_rd_i |=> !reg_rvalid_o); // R13

endmodule

bind trig_combiner trig_combiner_chk #(.NUM_CH(NUM_CH), .TYPE_W(TYPE_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_i),
    .reg_rd_i     (reg_rd_i),
    .reg_rvalid_o (reg_rvalid_o),
    .trig_o       (trig_o),
    .trig_type_o  (trig_type_o),
    .cfg_en       (cfg_en)
);

// File: tb/trig_combiner_tb.sv
module trig_combiner_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chan = '0;
    logic        busy = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic        trig;
    logic [3:0]  typ;

    int    n_checks = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    trig_combiner #(
        .NUM_CH(16), .TYPE_W(4), .CNT_W(8), .DATA_W(32), .ADDR_W(8), .CNT_BASE(16)
    ) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .chan_i       (chan),
        .busy_i       (busy),
        .reg_wr_i     (wr),
        .reg_rd_i     (rd),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .reg_rvalid_o (rvalid),
        .trig_o       (trig),
        .trig_type_o  (typ)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model (scoreboard producer) ----------------
    typedef struct {
        logic       trig;
        logic [3:0] typ;
        string      tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] rd_q[$];
    string       rdtag_q[$];

    logic [15:0] m_en, m_lvl, m_prev, m_act;
    logic [3:0]  m_types [16];
    logic        m_trig;
    logic [3:0]  m_type;
    logic [7:0]  m_lvlc [16];
    logic [7:0]  m_edgc [16];

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] v;
        int          idx;
        v = '0;
        if (a == 8'h00) begin
            v = {m_lvl, m_en};
        end else if (a == 8'h01) begin
            for (int c = 0; c < 8; c++) v[4*c +: 4] = m_types[c];
        end else if (a == 8'h02) begin
            for (int c = 0; c < 8; c++) v[4*c +: 4] = m_types[c+8];
        end else if (a >= 8'h10 && a < 8'h30) begin
            idx = (int'(a) - 16) / 2;
            v = a[0] ? 32'(m_edgc[idx]) : 32'(m_lvlc[idx]);
        end
        return v;
    endfunction

    always @(posedge clk) begin : model
        logic        nt;
        logic [3:0]  nty;
        logic [15:0] rise;
        if (!rst_n) begin
            m_en = '0; m_lvl = '0; m_prev = '0; m_act = '0;
            m_trig = 1'b0; m_type = '0;
            for (int c = 0; c < 16; c++) begin
                m_types[c] = '0; m_lvlc[c] = '0; m_edgc[c] = '0;
            end
        end else begin
            if (rd) begin
                rd_q.push_back(model_read(addr));
                rdtag_q.push_back(cur_req);
            end
            nt  = (|m_act) && !busy;
            nty = '0;
            for (int c = 15; c >= 0; c--) if (m_act[c]) nty = m_types[c];
            if (nt && !m_trig) m_type = nty;
            m_trig = nt;
            exp_q.push_back('{m_trig, m_type, cur_req});
            rise  = chan & ~m_prev;
            m_act = m_en & ((m_lvl & chan) | (~m_lvl & rise));
            for (int c = 0; c < 16; c++) begin
                if (chan[c]) m_lvlc[c] = m_lvlc[c] + 8'd1;
                if (rise[c]) m_edgc[c] = m_edgc[c] + 8'd1;
            end
            m_prev = chan;
            if (wr) begin
                if (addr == 8'h00) {m_lvl, m_en} = wdata;
                if (addr == 8'h01) for (int c = 0; c < 8; c++) m_types[c] = wdata[4*c +: 4];
                if (addr == 8'h02) for (int c = 0; c < 8; c++) m_types[c+8] = wdata[4*c +: 4];
            end
        end
    end

    // ---------------- monitor (scoreboard consumer) ----------------
    always @(negedge clk) begin : monitor
        exp_t        e;
        logic [31:0] x;
        string       t;
        if (rst_n && !done) begin
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(trig === e.trig && typ === e.typ, e.tag, {trig, typ}, {e.trig, e.typ});
            end
            if (rd_q.size() > 0) begin
                x = rd_q.pop_front();
                t = rdtag_q.pop_front();
                chk(rvalid === 1'b1 && rdata === x, t, {rvalid, rdata}, {1'b1, x});
            end else begin
                chk(rvalid === 1'b0, "R13", rvalid, 0);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        step(1);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd = 1'b1; addr = a;
        step(1);
        rd = 1'b0;
        chk(rvalid === 1'b1 && rdata === exp, tag, rdata, exp);
    endtask

    task automatic finish_sim();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_sim();
        end
    end

    initial begin : stimulus
        int cnt;
        step(3);
        #1 rst_n = 1'b1;
        step(1);

        // R1: reset state
        cur_req = "R1";
        chk(trig === 1'b0, "R1", trig, 0);
        chk(typ === 4'h0, "R1", typ, 0);
        reg_read(8'h00, 32'h0, "R1");
        reg_read(8'h01, 32'h0, "R1");
        reg_read(8'h02, 32'h0, "R1");
        cur_req = "R13";
        reg_read(8'h05, 32'h0, "R13");
        reg_read(8'h7F, 32'h0, "R13");

        // R3: disabled channels never trigger
        cur_req = "R3";
        chan = 16'h3FFF;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin step(1); cnt += int'(trig); end
        chk(cnt == 0, "R3", cnt, 0);
        chan = '0;
        step(2);

        // R6: type table
        cur_req = "R6";
        reg_write(8'h01, 32'h8765_4321);
        reg_write(8'h02, 32'hFEDC_BA09);
        reg_read(8'h01, 32'h8765_4321, "R6");
        reg_read(8'h02, 32'hFEDC_BA09, "R6");

        // R2 / R4: channel 3 level sensitive
        cur_req = "R2";
        reg_write(8'h00, 32'h0008_0008);
        reg_read(8'h00, 32'h0008_0008, "R2");
        cur_req = "R4";
        chan[3] = 1'b1;
        step(1);
        chk(trig === 1'b0, "R4", trig, 0);
        step(1);
        chk(trig === 1'b1 && typ === 4'h4, "R4", {trig, typ}, {1'b1, 4'h4});
        step(3);
        chk(trig === 1'b1, "R4", trig, 1);
        chan = '0;
        step(2);
        chk(trig === 1'b0, "R4", trig, 0);

        // R5: channel 5 edge sensitive, held high
        cur_req = "R5";
        reg_write(8'h00, 32'h0000_0020);
        chan[5] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 7; i++) begin
            step(1);
            cnt += int'(trig);
            if (i == 1) chk(trig === 1'b1 && typ === 4'h6, "R5", {trig, typ}, {1'b1, 4'h6});
        end
        chk(cnt == 1, "R5", cnt, 1);
        chan = '0;
        step(2);

        // R7: lowest active channel selects the type
        cur_req = "R7";
        reg_write(8'h00, 32'h0000_0404);
        chan[2] = 1'b1; chan[10] = 1'b1;
        step(2);
        chk(trig === 1'b1 && typ === 4'h3, "R7", {trig, typ}, {1'b1, 4'h3});
        chan = '0;
        step(3);
        chan[10] = 1'b1;
        step(2);
        chk(trig === 1'b1 && typ === 4'hA, "R7", {trig, typ}, {1'b1, 4'hA});
        chan = '0;
        step(3);

        // R8: busy drops an edge event
        cur_req = "R8";
        busy = 1'b1;
        chan[10] = 1'b1;
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            cnt += int'(trig);
            if (i == 3) busy = 1'b0;
        end
        chk(cnt == 0, "R8", cnt, 0);
        chan = '0;
        step(2);

        // R9: type held while a level trigger continues
        cur_req = "R9";
        reg_write(8'h00, 32'h0024_0024);
        chan[5] = 1'b1;
        step(3);
        chk(trig === 1'b1 && typ === 4'h6, "R9", {trig, typ}, {1'b1, 4'h6});
        chan[2] = 1'b1;
        step(3);
        chk(trig === 1'b1 && typ === 4'h6, "R9", {trig, typ}, {1'b1, 4'h6});
        chan = '0;
        step(3);
        chk(trig === 1'b0, "R9", trig, 0);
        chan[2] = 1'b1;
        step(2);
        chk(trig === 1'b1 && typ === 4'h3, "R9", {trig, typ}, {1'b1, 4'h3});
        chan = '0;
        step(3);

        // R10 / R11: disabled channel 15, three pulses of two cycles
        cur_req = "R10";
        for (int p = 0; p < 3; p++) begin
            chan[15] = 1'b1; step(2);
            chan[15] = 1'b0; step(1);
        end
        reg_read(8'h2E, 32'd6, "R10");
        cur_req = "R11";
        reg_read(8'h2F, 32'd3, "R11");

        // R12: channel 14 high for 260 cycles wraps an 8-bit counter
        cur_req = "R12";
        chan[14] = 1'b1;
        step(260);
        chan[14] = 1'b0;
        step(2);
        reg_read(8'h2C, 32'd4, "R12");
        reg_read(8'h2D, 32'd1, "R11");

        step(3);
        finish_sim();
    end

endmodule